// File: doc/BRIEF.md
# UART Transmit Queue with Low-Water Status

This block is the transmit-side byte queue of a UART. A host pushes characters in through a data-register write strobe, and the serializer takes them out one at a time from the head. The queue holds 32 bytes by default. The host-side word may be wider than a byte, but only its low 8 bits are stored.

The block raises a transmitter-ready status when few bytes remain queued. It compares a programmable low-water mark with the number of bytes still waiting, not with the number of free slots. With a mark of 8, an asserted status therefore means that at least 24 more bytes fit, so a driver can write that many after each interrupt without polling. An enable bit gates the status onto an interrupt line.

Other outputs are:
- an empty flag;
- a transmit-complete flag, high when the queue is empty and the serializer reports idle;
- a sticky flag that records any write attempted while the queue was full.

Top module: `uart_txq_lowater`

## Requirements
- R1: After reset the queue is empty: `level` is 0, `empty` is 1, `tx_ready` is 1 and `overflow` is 0.
- R2: Bytes leave in the order they were written. `head_data` shows the oldest queued byte whenever `empty` is 0, and a `pop` in that cycle removes it.
- R3: A write stores only bits [7:0] of `wr_data`. The upper bits are never visible on `head_data`.
- R4: A write while `level` equals the depth (32) is dropped and leaves the queued bytes unchanged. From the next cycle `overflow` reads 1, and it stays 1 until reset.
- R5: `tx_ready` is 1 exactly when `level` is less than or equal to `low_mark`. The mark counts bytes still queued, so a mark of 8 with `tx_ready` high guarantees room for 24 more writes.
- R6: `tx_irq` equals `tx_ready` AND `irq_en`.
- R7: `empty` is 1 exactly when `level` is 0. A `pop` while empty is ignored.
- R8: `tx_done` is 1 exactly when `empty` is 1 and `ser_busy` is 0.
- R9: A write and a pop in the same cycle, with the queue neither empty nor full, leave `level` unchanged and keep both bytes in order.
- R10: `level` rises by one per accepted write and falls by one per accepted pop. It never exceeds the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe into the queue |
| wr_data | input | 16 | Host write word; only [7:0] is stored |
| pop | input | 1 | Serializer takes the head byte |
| ser_busy | input | 1 | Serializer is shifting a character |
| low_mark | input | 6 | Low-water mark, in bytes still queued |
| irq_en | input | 1 | Enables `tx_ready` onto `tx_irq` |
| head_data | output | 8 | Oldest queued byte |
| level | output | 6 | Number of bytes queued |
| empty | output | 1 | Queue holds no byte |
| tx_ready | output | 1 | Level is at or below the mark |
| tx_irq | output | 1 | Gated ready interrupt |
| tx_done | output | 1 | Queue empty and serializer idle |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
Random phases bias the write and pop rates three ways:
- Write-heavy phases drive the queue full and into dropped writes.
- Pop-heavy phases drain it and try pops on an empty queue.
- Balanced phases hover near the mark and exercise simultaneous push and pop.

Throughout, the mark, `irq_en` and `ser_busy` are re-drawn at random. This separates a comparison against bytes queued from one against free space, and it exposes off-by-one errors at the equality point.

Directed cases pin down further corner behaviour:
- an exact fill to 32 followed by an extra write;
- the mark-of-8 boundary at levels 8 and 9;
- the high data bits being discarded.

// File: rtl/txq_pkg.sv
package txq_pkg;
   typedef logic [7:0] txq_byte_t;
endpackage

// File: rtl/txq_store.sv
module txq_store
   import txq_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int WORD_W = 16,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              pop,
   output txq_byte_t         head_data,
   output logic [CNT_W-1:0]  count,
   output logic              ovf
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   txq_byte_t        mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr, wptr_nx, rptr_nx;
   logic             is_full, is_empty, w_acc, p_acc;

   assign is_full  = (count == FULL_CNT);
   assign is_empty = (count == '0);
   assign w_acc    = wr_en && !is_full;
   assign p_acc    = pop && !is_empty;

   generate
      if (POW2) begin : g_wrap_nat
         assign wptr_nx = wptr + 1'b1;
         assign rptr_nx = rptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wptr_nx = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rptr_nx = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (w_acc) mem[wptr] <= wr_data[7:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         if (w_acc) wptr <= wptr_nx;
         if (p_acc) rptr <= rptr_nx;
         case ({w_acc, p_acc})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (wr_en && is_full) ovf <= 1'b1;
      end
   end

   assign head_data = mem[rptr];

   assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
   assert_level_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1)
               || (count == $past(count) - 1'b1));
   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_full && wr_en && !pop) |=> (count == FULL_CNT) && ovf);
   assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_empty && pop && !wr_en) |=> (count == '0));
endmodule

// File: rtl/txq_mark.sv
module txq_mark #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] low_mark,
   input  logic             irq_en,
   input  logic             ser_busy,
   output logic             ready,
   output logic             irq,
   output logic             is_empty,
   output logic             done
);
   assign is_empty = (count == '0);
   assign ready    = (count <= low_mark);
   assign irq      = ready && irq_en;
   assign done     = is_empty && !ser_busy;

   assert_empty_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      is_empty |-> ready);
   assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_en && ready));
endmodule

// File: rtl/uart_txq_lowater.sv
module uart_txq_lowater
   import txq_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int WORD_W = 16,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              pop,
   input  logic              ser_busy,
   input  logic [CNT_W-1:0]  low_mark,
   input  logic              irq_en,
   output logic [7:0]        head_data,
   output logic [CNT_W-1:0]  level,
   output logic              empty,
   output logic              tx_ready,
   output logic              tx_irq,
   output logic              tx_done,
   output logic              overflow
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (WORD_W < 8) begin : g_bad_word
         $error("WORD_W must hold a byte");
      end
      if (CNT_W < $clog2(DEPTH + 1)) begin : g_bad_cnt
         $error("CNT_W too narrow for DEPTH");
      end
   endgenerate

   txq_byte_t head_b;

   txq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .pop       (pop),
      .head_data (head_b),
      .count     (level),
      .ovf       (overflow)
   );

   txq_mark #(.CNT_W(CNT_W)) u_mark (
      .clk      (clk),
      .rst_n    (rst_n),
      .count    (level),
      .low_mark (low_mark),
      .irq_en   (irq_en),
      .ser_busy (ser_busy),
      .ready    (tx_ready),
      .irq      (tx_irq),
      .is_empty (empty),
      .done     (tx_done)
   );

   assign head_data = head_b;

   assert_done_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> (empty && !ser_busy));
   assert_write_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !pop && !overflow && empty) |=> (level == CNT_W'(1)));
endmodule

// File: tb/uart_txq_lowater_bench.sv
module uart_txq_lowater_bench;
   localparam int DEPTH = 32;
   localparam int CW    = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, pop = 1'b0, ser_busy = 1'b0, irq_en = 1'b0;
   logic [15:0]   wr_data = '0;
   logic [CW-1:0] low_mark = '0;
   logic [7:0]    head_data;
   logic [CW-1:0] level;
   logic          empty, tx_ready, tx_irq, tx_done, overflow;

   int n_chk = 0, n_bad = 0;
   logic [7:0] q[$];
   bit m_ovf = 0;

   always #5 clk = ~clk;

   uart_txq_lowater u_uart_txq_lowater (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
      .ser_busy(ser_busy), .low_mark(low_mark), .irq_en(irq_en),
      .head_data(head_data), .level(level), .empty(empty), .tx_ready(tx_ready),
      .tx_irq(tx_irq), .tx_done(tx_done), .overflow(overflow)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_ready(int lvl, int mk);
      return (lvl <= mk) ? 1 : 0;
   endfunction

   // Drive one cycle at the falling edge, compare outputs, then advance the model.
   task automatic step(bit w, logic [15:0] d, bit p, int mk, bit en, bit busy);
      int sz;
      bit full;
      @(negedge clk);
      wr_en = w; wr_data = d; pop = p;
      low_mark = CW'(mk); irq_en = en; ser_busy = busy;
      #1;
      sz = q.size();
      check("R10 level", int'(level), sz);
      check("R7 empty", int'(empty), (sz == 0) ? 1 : 0);
      check("R5 tx_ready", int'(tx_ready), exp_ready(sz, mk));
      check("R6 tx_irq", int'(tx_irq), exp_ready(sz, mk) & int'(en));
      check("R8 tx_done", int'(tx_done), ((sz == 0) && !busy) ? 1 : 0);
      check("R4 overflow", int'(overflow), int'(m_ovf));
      if (sz > 0) check("R2 head order", int'(head_data), int'(q[0]));
      full = (sz == DEPTH);
      if (p && sz > 0) void'(q.pop_front());
      if (w && !full) q.push_back(d[7:0]);
      if (w && full) m_ovf = 1;
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int wp, pp;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 level", int'(level), 0);
      check("R1 empty", int'(empty), 1);
      check("R1 tx_ready", int'(tx_ready), 1);
      check("R1 overflow", int'(overflow), 0);

      // R7 pop on empty ignored
      step(0, 16'h0, 1, 8, 1, 0);
      // R3 high bits dropped
      step(1, 16'hA55A, 0, 8, 1, 0);
      step(0, 16'h0, 0, 8, 1, 1);
      check("R3 low byte only", int'(head_data), 8'h5A);
      step(0, 16'h0, 1, 8, 1, 0);

      // R5 mark boundary: fill to 8 then 9 with mark 8
      for (int i = 0; i < 8; i++) step(1, 16'(i + 16'h100), 0, 8, 1, 1);
      step(0, 16'h0, 0, 8, 1, 1);
      check("R5 ready at level 8 mark 8", int'(tx_ready), 1);
      step(1, 16'h77, 0, 8, 1, 1);
      step(0, 16'h0, 0, 8, 1, 1);
      check("R5 not ready at level 9 mark 8", int'(tx_ready), 0);

      // R9 simultaneous write and pop keeps level
      step(1, 16'hC3, 1, 8, 0, 1);
      step(0, 16'h0, 0, 8, 0, 1);
      check("R9 level held", int'(level), 9);

      // R4 fill to full then extra write
      while (q.size() < DEPTH) step(1, 16'($urandom), 0, 24, 1, 1);
      step(1, 16'hEE, 0, 24, 1, 1);
      step(0, 16'h0, 0, 24, 1, 1);
      check("R4 level stays full", int'(level), DEPTH);
      check("R4 overflow sticky set", int'(overflow), 1);
      // drain in order
      while (q.size() > 0) step(0, 16'h0, 1, 24, 1, 0);
      step(0, 16'h0, 0, 24, 1, 0);
      check("R8 done after drain", int'(tx_done), 1);
      check("R4 overflow still set", int'(overflow), 1);

      // random phases
      for (int ph = 0; ph < 12; ph++) begin
         case (ph % 3)
            0: begin wp = 85; pp = 20; end
            1: begin wp = 20; pp = 85; end
            default: begin wp = 55; pp = 50; end
         endcase
         for (int c = 0; c < 250; c++)
            step(($urandom % 100) < wp, 16'($urandom), ($urandom % 100) < pp,
                 int'($urandom % 33), 1'($urandom), 1'($urandom));
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule